// File: doc/BRIEF.md
# Serial Full-Capacity Output with Re-Encode Error Flag

This block sits behind a convolutional decoder. It turns each hard-decision bit the decoder produces into one serial output bit on a burst clock. The bits carry no framing or formatting. A window signal travels with the data. Depending on a mode input, the window either separates the fast information channel (window high) from main service channel data (window low), or it marks the first bit of each selected sub-channel.

Each output bit also carries an error flag. The block runs its own copy of the convolutional encoder on the decoded stream: rate 1/4, constraint length 7, generators 133, 171, 145 and 133 octal. It then compares the re-encoded bits with the code bits the decoder received. Only positions the received stream marks as present take part in the comparison, so punctured positions never raise the flag. The encoder history is cleared at each frame start.

The burst clock idles high. For each new bit it falls, and data, flag and window change on that same edge. It stays low for `HALF_P` system cycles, then rises, so every output is stable around the rising edge. Upstream must space decoded bits at least `2*HALF_P` cycles apart.

Top module: `fco_out`

## Requirements
- R1: While reset is asserted and until the first decoded bit arrives, `sc_clk` is high and `sc_data`, `sc_err` and `sc_win` are low.
- R2: Each accepted bit (`bit_valid` high on a clock edge) produces exactly one burst clock pulse. `sc_clk` falls on the accepting edge, stays low for exactly `HALF_P` clock cycles, and then stays high until the next accepted bit.
- R3: `sc_data` carries the decoded bits in arrival order, one bit per pulse, with nothing inserted or dropped.
- R4: With `mode_sel` = 1, `sc_win` equals the `is_fic` value given with the bit (1 = fast information channel, 0 = main service channel).
- R5: With `mode_sel` = 0, `sc_win` equals the `subch_start` value given with the bit, so it is high only for a bit that begins a selected sub-channel.
- R6: `sc_err` is 1 when any present received code bit differs from the re-encoded bit. The window is w = {b[n], b[n-1], ..., b[n-6]}, with the newest bit as MSB. Re-encoded bit i is the XOR over (w AND G[i]), where G[0]=133, G[1]=171, G[2]=145 and G[3]=133 (octal). `rx_code[i]` is compared with bit i.
- R7: A position with `rx_present[i]` = 0 never contributes to `sc_err`, whatever its `rx_code[i]` value.
- R8: When `frame_start` accompanies a bit, all history bits b[n-1]..b[n-6] are taken as 0 for that bit's re-encoding.
- R9: `sc_data`, `sc_err` and `sc_win` change only on a falling edge of `sc_clk`.
- R10: Usage rule: `bit_valid` is high at most once in any `2*HALF_P` consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_valid | input | 1 | A decoded bit is offered in this cycle |
| bit_data | input | 1 | Decoded bit |
| frame_start | input | 1 | This bit is the first of a frame; clears encoder history |
| rx_code | input | 4 | Received code bits matching this decoded bit |
| rx_present | input | 4 | Per code bit: 1 = transmitted, 0 = punctured |
| is_fic | input | 1 | Bit belongs to the fast information channel |
| subch_start | input | 1 | Bit begins a selected sub-channel |
| mode_sel | input | 1 | 1 = window shows channel type, 0 = window marks sub-channel starts |
| sc_clk | output | 1 | Burst clock, one pulse per bit |
| sc_data | output | 1 | Serial decoded data |
| sc_err | output | 1 | Re-encode mismatch flag for the current bit |
| sc_win | output | 1 | Framing window |

## Verification
Several properties are checked on every cycle: the outputs stay stable away from the falling edge of the burst clock, the clock is low exactly during the first `HALF_P` cycles after a bit and high otherwise, punctured-only bits never raise the flag, the window follows the selected source in both modes, and input bits respect the minimum spacing. The following can only be shown by the bench's scenarios, which compare against an independent encoder model: that the flag uses the right generators and history, that a frame start clears that history, that the bit order is kept, and that no pulse is missing or extra.

// File: rtl/fco_pkg.sv
package fco_pkg;
  localparam int unsigned CL     = 7;
  localparam int unsigned N_CODE = 4;
  localparam int unsigned HIST_W = CL - 1;

  typedef logic [CL-1:0]     gen_t;
  typedef logic [N_CODE-1:0] code_t;

  localparam gen_t GENS [N_CODE] = '{7'o133, 7'o171, 7'o145, 7'o133};

  function automatic code_t reencode(input gen_t win);
    code_t r;
    for (int i = 0; i < N_CODE; i++) r[i] = ^(win & GENS[i]);
    return r;
  endfunction
endpackage

// File: rtl/fco_reenc.sv
module fco_reenc
  import fco_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  bit_in,
  input  logic  frame_start,
  input  code_t rx_code,
  input  code_t rx_present,
  output logic  mismatch
);
  logic [HIST_W-1:0] hist_q, hist_nxt, hist_base;
  gen_t              win;
  code_t             expect_code;

  always_comb begin
    hist_base   = frame_start ? '0 : hist_q;
    win         = {bit_in, hist_base};
    expect_code = reencode(win);
    mismatch    = |((expect_code ^ rx_code) & rx_present);
    hist_nxt    = hist_q;
    if (take) hist_nxt = {bit_in, hist_base[HIST_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_nxt;
  end

  // R7: punctured-only input can never report a mismatch
  p_punct_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_present == '0) |-> !mismatch);
endmodule

// File: rtl/fco_burst.sv
module fco_burst #(
  parameter int unsigned HALF_P = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic burst_clk
);
  localparam int unsigned CNT_W = $clog2(HALF_P + 1) + 1;

  logic             clk_q, clk_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    clk_nxt = clk_q;
    cnt_nxt = cnt_q;
    if (take) begin
      clk_nxt = 1'b0;
      cnt_nxt = CNT_W'(1);
    end else if (!clk_q) begin
      if (cnt_q == CNT_W'(HALF_P)) clk_nxt = 1'b1;
      else                         cnt_nxt = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      clk_q <= clk_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign burst_clk = clk_q;
endmodule

// File: rtl/fco_out.sv
module fco_out
  import fco_pkg::*;
#(
  parameter int unsigned HALF_P = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       bit_data,
  input  logic       frame_start,
  input  logic [3:0] rx_code,
  input  logic [3:0] rx_present,
  input  logic       is_fic,
  input  logic       subch_start,
  input  logic       mode_sel,
  output logic       sc_clk,
  output logic       sc_data,
  output logic       sc_err,
  output logic       sc_win
);
  localparam int unsigned GAP_MAX = 2 * HALF_P;
  localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1) + 1;

  logic mismatch;
  logic data_q, err_q, win_q;
  logic data_nxt, err_nxt, win_nxt;

  fco_reenc u_reenc (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (bit_valid),
    .bit_in      (bit_data),
    .frame_start (frame_start),
    .rx_code     (rx_code),
    .rx_present  (rx_present),
    .mismatch    (mismatch)
  );

  fco_burst #(.HALF_P(HALF_P)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (bit_valid),
    .burst_clk (sc_clk)
  );

  always_comb begin
    data_nxt = data_q;
    err_nxt  = err_q;
    win_nxt  = win_q;
    if (bit_valid) begin
      data_nxt = bit_data;
      err_nxt  = mismatch;
      win_nxt  = mode_sel ? is_fic : subch_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      err_q  <= 1'b0;
      win_q  <= 1'b0;
    end else begin
      data_q <= data_nxt;
      err_q  <= err_nxt;
      win_q  <= win_nxt;
    end
  end

  assign sc_data = data_q;
  assign sc_err  = err_q;
  assign sc_win  = win_q;

  // Assertion support: cycles since the last accepted bit (saturating)
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       gap_q <= GAP_W'(GAP_MAX);
    else if (bit_valid)               gap_q <= GAP_W'(1);
    else if (gap_q < GAP_W'(GAP_MAX)) gap_q <= gap_q + GAP_W'(1);
  end

  p_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (gap_q >= GAP_W'(GAP_MAX)));

  p_low_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q <= GAP_W'(HALF_P)) |-> !sc_clk);

  p_high_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q > GAP_W'(HALF_P)) |-> sc_clk);

  p_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sc_clk) |-> $stable({sc_data, sc_err, sc_win}));

  p_win_fic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && mode_sel) |=> (sc_win == $past(is_fic)));

  p_win_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !mode_sel) |=> (sc_win == $past(subch_start)));

  p_punct_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && rx_present == 4'h0) |=> !sc_err);
endmodule

// File: tb/fco_out_tb.sv
`timescale 1ns/1ps
module fco_out_tb;
  localparam int unsigned HALF_P = 8;
  localparam real         TCLK   = 20.0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_valid, bit_data, frame_start, is_fic, subch_start, mode_sel;
  logic [3:0] rx_code, rx_present;
  logic       sc_clk, sc_data, sc_err, sc_win;

  always #10 clk = ~clk;

  fco_out #(.HALF_P(HALF_P)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .frame_start(frame_start), .rx_code(rx_code), .rx_present(rx_present),
    .is_fic(is_fic), .subch_start(subch_start), .mode_sel(mode_sel),
    .sc_clk(sc_clk), .sc_data(sc_data), .sc_err(sc_err), .sc_win(sc_win)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;
  int pulses = 0;
  int sent   = 0;

  logic [2:0] q_exp [$];   // {data, err, win}
  string      q_tag [$];
  logic [5:0] m_hist = '0; // m_hist[5] = previous bit

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] model_code(input logic b, input logic [5:0] h);
    logic [6:0] g [4];
    logic [6:0] w;
    logic [3:0] r;
    g[0] = 7'o133; g[1] = 7'o171; g[2] = 7'o145; g[3] = 7'o133;
    w = {b, h};
    for (int i = 0; i < 4; i++) r[i] = ^(w & g[i]);
    return r;
  endfunction

  task automatic send(input logic b, input logic fs, input logic fic, input logic sub,
                      input logic [3:0] flip, input logic [3:0] pres, input string etag);
    logic [5:0] h;
    logic [3:0] good;
    h    = fs ? 6'h00 : m_hist;
    good = model_code(b, h);
    m_hist = {b, h[5:1]};
    q_exp.push_back({b, |(flip & pres), mode_sel ? fic : sub});
    q_tag.push_back(etag);
    @(negedge clk);
    bit_valid = 1'b1; bit_data = b; frame_start = fs; is_fic = fic; subch_start = sub;
    rx_code = good ^ flip; rx_present = pres;
    sent++;
    @(negedge clk);
    bit_valid = 1'b0; frame_start = 1'b0; rx_code = 4'h0; rx_present = 4'h0;
    repeat (2 * HALF_P - 2) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard at every burst clock rise
  initial begin
    realtime t_fall, t_rise;
    logic [2:0] e;
    string t;
    wait (mon_on);
    forever begin
      @(negedge sc_clk); t_fall = $realtime;
      @(posedge sc_clk); t_rise = $realtime;
      #1;
      pulses++;
      check("R2 low width", 8'(int'((t_rise - t_fall) / TCLK)), 8'(HALF_P));
      if (q_exp.size() == 0) begin
        check("R2 extra pulse", 8'd1, 8'd0);
      end else begin
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check("R3 data", {7'd0, sc_data}, {7'd0, e[2]});
        check(t,         {7'd0, sc_err},  {7'd0, e[1]});
        check(mode_sel ? "R4 window" : "R5 window", {7'd0, sc_win}, {7'd0, e[0]});
        #((HALF_P / 2) * TCLK);
        check("R9 hold while high", {5'd0, sc_data, sc_err, sc_win}, {5'd0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_valid = 1'b0; bit_data = 1'b0; frame_start = 1'b0;
    is_fic = 1'b0; subch_start = 1'b0; mode_sel = 1'b1;
    rx_code = 4'h0; rx_present = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 reset", {4'd0, sc_clk, sc_data, sc_err, sc_win}, 8'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle", {4'd0, sc_clk, sc_data, sc_err, sc_win}, 8'b1000);
    mon_on = 1'b1;

    // R3/R4/R6: clean frame, channel-type window
    send(1, 1, 1, 0, 4'h0, 4'hF, "R6 clean");
    send(0, 0, 1, 0, 4'h0, 4'hF, "R6 clean");
    send(1, 0, 1, 1, 4'h0, 4'hF, "R6 clean");
    send(1, 0, 0, 0, 4'h0, 4'hF, "R6 clean");
    send(0, 0, 0, 1, 4'h0, 4'hF, "R6 clean");
    send(1, 0, 0, 0, 4'h0, 4'hF, "R6 clean");
    // R6: single corrupted code bit in each position
    send(0, 0, 0, 0, 4'h1, 4'hF, "R6 flip0");
    send(1, 0, 0, 0, 4'h2, 4'hF, "R6 flip1");
    send(1, 0, 1, 0, 4'h4, 4'hF, "R6 flip2");
    send(0, 0, 1, 0, 4'h8, 4'hF, "R6 flip3");
    // R7: corruption only on punctured positions
    send(1, 0, 0, 0, 4'hF, 4'h0, "R7 all punctured");
    send(0, 0, 0, 0, 4'h5, 4'hA, "R7 partial");
    send(1, 0, 0, 0, 4'h6, 4'h3, "R7 one present wrong");
    // R8: frame start after non-zero history
    send(1, 0, 0, 0, 4'h0, 4'hF, "R6 clean");
    send(1, 0, 0, 0, 4'h0, 4'hF, "R6 clean");
    send(1, 1, 1, 0, 4'h0, 4'hF, "R8 cleared history");
    send(0, 0, 1, 0, 4'h0, 4'hF, "R8 after clear");
    // R5: sub-channel start window
    repeat (2 * HALF_P) @(negedge clk);
    mode_sel = 1'b0;
    send(1, 0, 1, 1, 4'h0, 4'hF, "R6 clean");
    send(0, 0, 1, 0, 4'h0, 4'hF, "R6 clean");
    send(1, 0, 0, 0, 4'h3, 4'hC, "R7 mode0");
    send(0, 0, 0, 1, 4'h9, 4'hF, "R6 mode0 flip");
    send(0, 0, 1, 0, 4'h0, 4'hF, "R6 clean");

    repeat (4 * HALF_P) @(negedge clk);
    check("R2 pulse count", 8'(pulses), 8'(sent));
    check("R3 queue drained", 8'(q_exp.size()), 8'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule